// File: doc/BRIEF.md
# Bit-Serial Real-Time-Clock Register Access Engine

This block is the host-side master for a real-time-clock device that exchanges data over a single bidirectional data line. Three active-low strobes go with that line: a chip select, a write strobe and a read strobe. A client issues one request at a time on a valid/ready handshake. Each request carries a read/write flag, a 4-bit register address and 8 bits of write data. The engine turns the request into a series of bit cycles and pulses a done flag when the series ends. For reads, the assembled byte is valid at that point.

Each bit is a complete transfer of its own. Chip select and one strobe go low around a single bit on the shared pin, and both rise again before the next bit starts. The address always goes out first. A register write then sends 8 data bits. A register read then collects 8 bits, with the line released. Addresses at or above a parameterised threshold are commands, and they stop after the address. The strobe widths and the idle gaps are set in system clock cycles by the parameter `STROBE_CYC`, so the same RTL serves any system clock frequency. The block drives the pin through a separate output value and output enable. The pad's tri-state buffer sits outside the block.

Top module: `rtc_serial_master`

## Requirements
- R1: While reset is applied and after it is released, `rtc_cs_n`, `rtc_wr_n` and `rtc_rd_n` are 1, `rtc_io_oe` is 0, `rsp_done` is 0 and `req_ready` is 1 once the engine is idle.
- R2: Every transaction begins with the 4 address bits, least-significant bit first, one bit for each write-strobe cycle.
- R3: A write request (`req_rd`=0) to a non-command address sends the 8 bits of `req_wdata` after the address, least-significant bit first, one bit for each write-strobe cycle.
- R4: An address whose value is at or above `CMD_BASE` is a command. It ends after the 4 address bits, whatever `req_rd` and `req_wdata` are, and `rsp_rdata` reads 0.
- R5: A read request (`req_rd`=1) to a non-command address performs exactly 8 read-strobe cycles after the address. Each sampled bit enters at bit 7 while the byte shifts right, so the first bit received lands in bit 0 of `rsp_rdata`. `rsp_rdata` is valid while `rsp_done` is high and is 0 after non-read requests.
- R6: In a write-bit cycle the data bit is already driven (`rtc_io_oe`=1) one cycle before the strobes fall. `rtc_wr_n` stays low for exactly `STROBE_CYC` cycles with `rtc_cs_n` low and `rtc_io_o` unchanged. `rtc_wr_n` rises one cycle before `rtc_cs_n`.
- R7: In a read-bit cycle `rtc_rd_n` stays low for exactly 2×`STROBE_CYC` cycles. The pin is sampled at the clock edge that ends the first `STROBE_CYC` low cycles. `rtc_rd_n` rises one cycle before `rtc_cs_n`, and the write and read strobes are never low together.
- R8: Within a transaction, `rtc_cs_n` stays high for exactly `STROBE_CYC`+1 cycles between consecutive bit cycles: an idle gap of `STROBE_CYC` cycles and one setup cycle.
- R9: `rtc_io_oe` is 0 from the setup cycle of the first read bit until the transaction ends, including every cycle in which `rtc_rd_n` is low.
- R10: `req_ready` is 1 only while the engine is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Changes to the request inputs while the engine is busy have no effect. `rsp_done` is a one-cycle pulse in the first idle cycle, so a held request is accepted in that same cycle.
- R11: From acceptance to `rsp_done`, a transaction takes 4×(2T+2) cycles, plus 8×(2T+2) for a write or 8×(3T+2) for a read, where T is `STROBE_CYC`. Commands take only the address part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_rd | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | ADDR_W (4) | Register or command address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_rdata | output | DATA_W (8) | Assembled read byte |
| rtc_cs_n | output | 1 | Chip select, active low |
| rtc_wr_n | output | 1 | Write strobe, active low |
| rtc_rd_n | output | 1 | Read strobe, active low |
| rtc_io_o | output | 1 | Value driven onto the data pin |
| rtc_io_oe | output | 1 | Data pin output enable |
| rtc_io_i | input | 1 | Value sensed on the data pin |

## Verification
Two events can fall in the same clock cycle: the done pulse that closes one transaction and the acceptance of the next request. The bench holds `req_valid` high across a whole write. It changes the address and data while the engine is busy. It then checks that `req_ready` and `rsp_done` are high together and that `req_ready` drops on the next cycle. The first transaction's bits must match its original request, and the second transaction's bits must match the changed inputs, with no lost or repeated bit. The device model presents the correct read bit only during the cycle in which the engine should sample it, and the inverse at all other times. A sample taken off by one cycle therefore shows up as a wrong byte.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

  // Phase of the current bit cycle
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LOW1  = 3'd2,
    PH_LOW2  = 3'd3,
    PH_REL   = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // Segment of the transaction the bit belongs to
  typedef enum logic [1:0] {
    SEG_ADDR  = 2'd0,
    SEG_WDATA = 2'd1,
    SEG_RDATA = 2'd2
  } seg_e;

endpackage

// File: rtl/rtc_ser_timer.sv
module rtc_ser_timer #(
  parameter int unsigned CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rtc_ser_shift.sv
module rtc_ser_shift #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_tx,
  input  logic              sample,
  input  logic              io_i,
  output logic              tx_bit_d,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned TX_W = ADDR_W + DATA_W;

  logic [TX_W-1:0]   tx_q, tx_d;
  logic              tx_en;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rx_en;

  // Transmit word: address in the low bits, data above; shifted right
  always_comb begin
    tx_en = capture || shift_tx;
    tx_d  = tx_q;
    if (capture)       tx_d = {wdata, addr};
    else if (shift_tx) tx_d = {1'b0, tx_q[TX_W-1:1]};
  end

  // Receive byte: new bit enters at the top, first bit ends at bit 0
  always_comb begin
    rx_en = capture || sample;
    rx_d  = rx_q;
    if (capture)     rx_d = '0;
    else if (sample) rx_d = {io_i, rx_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign tx_bit_d = tx_d[0];
  assign rx_byte  = rx_q;

endmodule

// File: rtl/rtc_ser_ctrl.sv
module rtc_ser_ctrl
  import rtc_ser_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CMD_BASE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic              capture,
  output logic              shift_tx,
  output logic              sample,
  output phase_e            ph_d,
  output seg_e              seg_d,
  output logic              ready,
  output logic              done
);
  localparam int unsigned MAXB = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int unsigned BW   = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [ADDR_W:0] CMD_LIM = (ADDR_W + 1)'(CMD_BASE);

  phase_e          ph_q;
  seg_e            seg_q;
  logic [BW-1:0]   bit_q, bit_d;
  logic            rd_q, rd_d, cmd_q, cmd_d, done_q, done_d;
  logic            req_cmd;

  assign req_cmd = ({1'b0, req_addr} >= CMD_LIM);

  always_comb begin
    ph_d     = ph_q;
    seg_d    = seg_q;
    bit_d    = bit_q;
    rd_d     = rd_q;
    cmd_d    = cmd_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    capture  = 1'b0;
    shift_tx = 1'b0;
    sample   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          capture = 1'b1;
          ph_d    = PH_SETUP;
          seg_d   = SEG_ADDR;
          bit_d   = BW'(ADDR_W - 1);
          rd_d    = req_rd;
          cmd_d   = req_cmd;
        end
      end
      PH_SETUP: begin
        ph_d     = PH_LOW1;
        tmr_load = 1'b1;
      end
      PH_LOW1: begin
        if (tmr_zero) begin
          if (seg_q == SEG_RDATA) begin
            sample   = 1'b1;
            ph_d     = PH_LOW2;
            tmr_load = 1'b1;
          end else begin
            ph_d = PH_REL;
          end
        end
      end
      PH_LOW2: begin
        if (tmr_zero) ph_d = PH_REL;
      end
      PH_REL: begin
        ph_d     = PH_GAP;
        tmr_load = 1'b1;
      end
      PH_GAP: begin
        if (tmr_zero) begin
          if (seg_q != SEG_RDATA) shift_tx = 1'b1;
          if (bit_q != '0) begin
            bit_d = bit_q - 1'b1;
            ph_d  = PH_SETUP;
          end else if (seg_q == SEG_ADDR && !cmd_q) begin
            seg_d = rd_q ? SEG_RDATA : SEG_WDATA;
            bit_d = BW'(DATA_W - 1);
            ph_d  = PH_SETUP;
          end else begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      seg_q  <= SEG_ADDR;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      cmd_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      seg_q  <= seg_d;
      bit_q  <= bit_d;
      rd_q   <= rd_d;
      cmd_q  <= cmd_d;
      done_q <= done_d;
    end
  end

  assign ready = (ph_q == PH_IDLE);
  assign done  = done_q;

  AST_CMD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && seg_q != SEG_ADDR) |-> !cmd_q); // R4
  AST_READ_SEG_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && seg_q == SEG_RDATA) |-> rd_q); // R5
  AST_BUSY_HOLDS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> ($stable(rd_q) && $stable(cmd_q))); // R10

endmodule

// File: rtl/rtc_ser_pins.sv
module rtc_ser_pins
  import rtc_ser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph_d,
  input  seg_e   seg_d,
  input  logic   tx_bit_d,
  output logic   cs_n,
  output logic   wr_n,
  output logic   rd_n,
  output logic   io_o,
  output logic   io_oe
);
  logic cs_n_d, wr_n_d, rd_n_d, io_o_d, io_oe_d;
  logic is_read, strobe_low;

  // Pin values are decoded from the next phase and registered
  always_comb begin
    is_read    = (seg_d == SEG_RDATA);
    strobe_low = (ph_d == PH_LOW1) || (ph_d == PH_LOW2);
    cs_n_d     = !(strobe_low || (ph_d == PH_REL));
    wr_n_d     = !(!is_read && (ph_d == PH_LOW1));
    rd_n_d     = !(is_read && strobe_low);
    io_oe_d    = (ph_d != PH_IDLE) && !is_read;
    io_o_d     = io_oe_d && tx_bit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      io_o  <= 1'b0;
      io_oe <= 1'b0;
    end else begin
      cs_n  <= cs_n_d;
      wr_n  <= wr_n_d;
      rd_n  <= rd_n_d;
      io_o  <= io_o_d;
      io_oe <= io_oe_d;
    end
  end

endmodule

// File: rtl/rtc_serial_master.sv
module rtc_serial_master
  import rtc_ser_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CMD_BASE   = 14,
  parameter int unsigned STROBE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rtc_cs_n,
  output logic              rtc_wr_n,
  output logic              rtc_rd_n,
  output logic              rtc_io_o,
  output logic              rtc_io_oe,
  input  logic              rtc_io_i
);
  logic   rst_meta_n, rst_s_n;
  logic   tmr_load, tmr_zero, capture, shift_tx, sample, tx_bit_d;
  phase_e ph_d;
  seg_e   seg_d;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  rtc_ser_timer #(.CYC(STROBE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (tmr_load),
    .zero  (tmr_zero)
  );

  rtc_ser_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CMD_BASE (CMD_BASE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .capture   (capture),
    .shift_tx  (shift_tx),
    .sample    (sample),
    .ph_d      (ph_d),
    .seg_d     (seg_d),
    .ready     (req_ready),
    .done      (rsp_done)
  );

  rtc_ser_shift #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .capture  (capture),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .shift_tx (shift_tx),
    .sample   (sample),
    .io_i     (rtc_io_i),
    .tx_bit_d (tx_bit_d),
    .rx_byte  (rsp_rdata)
  );

  rtc_ser_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ph_d     (ph_d),
    .seg_d    (seg_d),
    .tx_bit_d (tx_bit_d),
    .cs_n     (rtc_cs_n),
    .wr_n     (rtc_wr_n),
    .rd_n     (rtc_rd_n),
    .io_o     (rtc_io_o),
    .io_oe    (rtc_io_oe)
  );

  AST_STROBE_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rtc_cs_n) |-> ($past(rtc_wr_n) && $past(rtc_rd_n))); // R6
  AST_DRIVE_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(rtc_wr_n) |-> ($past(rtc_io_oe) && rtc_io_oe && !rtc_cs_n)); // R6
  AST_IO_HOLD_WR: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rtc_wr_n |-> $stable(rtc_io_o)); // R6
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rtc_wr_n |-> rtc_rd_n); // R7
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rtc_rd_n |-> (!rtc_io_oe && !$past(rtc_io_oe))); // R9
  AST_READY_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> (rtc_cs_n && rtc_wr_n && rtc_rd_n && !rtc_io_oe)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_done |=> !rsp_done); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_done |-> req_ready); // R10

endmodule

// File: tb/sim_rtc_serial_master.sv
`timescale 1ns/1ps
module sim_rtc_serial_master;
  localparam int T  = 2;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CB = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_rd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          rtc_cs_n, rtc_wr_n, rtc_rd_n, rtc_io_o, rtc_io_oe, rtc_io_i;
  logic [DW-1:0] model = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // Device model monitor state
  bit        acc_seen = 0;
  logic      p_wr = 1'b1, p_rd = 1'b1, p_cs = 1'b1, wr_io = 1'b0;
  int        wr_len = 0, rd_len = 0, csh_len = 0;
  int        cap_n = 0, rd_cnt = 0;
  logic [15:0] cap = '0;
  int        v_wr = 0, v_rd = 0, v_gap = 0, v_oe = 0, v_ord = 0;
  bit        seen_bit = 0;

  rtc_serial_master #(
    .ADDR_W(AW), .DATA_W(DW), .CMD_BASE(CB), .STROBE_CYC(T)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rtc_cs_n(rtc_cs_n), .rtc_wr_n(rtc_wr_n), .rtc_rd_n(rtc_rd_n),
    .rtc_io_o(rtc_io_o), .rtc_io_oe(rtc_io_oe), .rtc_io_i(rtc_io_i)
  );

  // Correct bit only in the cycle the engine must sample it (R7)
  assign rtc_io_i = (rd_len == T) ? model[rd_cnt[2:0]] : ~model[rd_cnt[2:0]];

  always @(posedge clk) acc_seen <= req_valid && req_ready;

  always @(negedge clk) begin
    if (acc_seen) begin
      cap_n = 0; cap = '0; rd_cnt = 0; seen_bit = 0;
      v_wr = 0; v_rd = 0; v_gap = 0; v_oe = 0; v_ord = 0;
    end
    if (!rtc_wr_n) begin
      if (p_wr) begin
        if (!rtc_io_oe) v_wr++;
        wr_io = rtc_io_o;
      end else if (rtc_io_o !== wr_io) v_wr++;
      wr_len++;
    end else begin
      if (!p_wr) begin
        if (wr_len != T) v_wr++;
        if (rtc_cs_n) v_ord++;
        if (cap_n < 16) cap[cap_n] = wr_io;
        cap_n++;
      end
      wr_len = 0;
    end
    if (!rtc_rd_n) begin
      if (rtc_io_oe) v_oe++;
      if (!rtc_wr_n) v_ord++;
      rd_len++;
    end else begin
      if (!p_rd) begin
        if (rd_len != 2*T) v_rd++;
        if (rtc_cs_n) v_ord++;
        rd_cnt++;
      end
      rd_len = 0;
    end
    if (rd_cnt > 0 && rtc_io_oe) v_oe++;
    if (!rtc_cs_n) begin
      if (p_cs) begin
        if (seen_bit && csh_len != T+1) v_gap++;
        seen_bit = 1;
      end
      csh_len = 0;
    end else csh_len++;
    p_wr = rtc_wr_n; p_rd = rtc_rd_n; p_cs = rtc_cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int txn_len(input bit rd, input int addr);
    int l = 4*(2*T+2);
    if (addr < CB) l += rd ? 8*(3*T+2) : 8*(2*T+2);
    return l;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!rsp_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(input bit rd, input int addr, input int wd, input int mdl, input int n);
    bit cmd = (addr >= CB);
    int exp_n = (cmd || rd) ? 4 : 12;
    int exp_r = (rd && !cmd) ? (mdl & 255) : 0;
    chk(n == txn_len(rd, addr), "R11 duration", n, txn_len(rd, addr));
    #1;
    chk(cap_n == exp_n, cmd ? "R4 bit count" : (rd ? "R2 bit count" : "R3 bit count"), cap_n, exp_n);
    chk(int'(cap[3:0]) == (addr & 15), "R2 address bits", int'(cap[3:0]), addr & 15);
    if (!rd && !cmd) chk(int'(cap[11:4]) == (wd & 255), "R3 data bits", int'(cap[11:4]), wd & 255);
    chk(rd_cnt == ((rd && !cmd) ? 8 : 0), cmd ? "R4 read strobes" : "R5 read strobes", rd_cnt, (rd && !cmd) ? 8 : 0);
    chk(int'(rsp_rdata) == exp_r, cmd ? "R4 rdata" : "R5 rdata", int'(rsp_rdata), exp_r);
    chk(v_wr == 0, "R6 write strobe", v_wr, 0);
    chk(v_rd == 0, "R7 read strobe", v_rd, 0);
    chk(v_ord == 0, "R7 strobe order", v_ord, 0);
    chk(v_gap == 0, "R8 gap", v_gap, 0);
    chk(v_oe == 0, "R9 output enable", v_oe, 0);
    chk(req_ready == 1'b1, "R10 ready at done", int'(req_ready), 1);
  endtask

  task automatic run_txn(input bit rd, input int addr, input int wd, input int mdl);
    int n;
    @(negedge clk);
    model = DW'(mdl); req_valid = 1'b1; req_rd = rd;
    req_addr = AW'(addr); req_wdata = DW'(wd);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy not ready", int'(req_ready), 0);
    wait_done(n);
    check_result(rd, addr, wd, mdl, n);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R10 done pulse", int'(rsp_done), 0);
  endtask

  initial begin
    #(200000*4);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rtc_cs_n && rtc_wr_n && rtc_rd_n, "R1 strobes in reset", int'({rtc_cs_n, rtc_wr_n, rtc_rd_n}), 7);
    chk(!rtc_io_oe && !rsp_done, "R1 oe/done in reset", int'({rtc_io_oe, rsp_done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && rtc_cs_n && rtc_wr_n && rtc_rd_n && !rtc_io_oe && !rsp_done,
        "R1 idle after reset", int'({req_ready, rtc_cs_n, rtc_wr_n, rtc_rd_n, rtc_io_oe, rsp_done}), 6'b111100);

    // Sweep every address as write and read (R2 R3 R4 R5)
    for (int a = 0; a < 16; a++) begin
      run_txn(1'b0, a, (a*37 + 5) & 255, 0);
      run_txn(1'b1, a, 8'hFF, (a*91 + 166) & 255);
    end
    run_txn(1'b0, 3, 8'h00, 0);
    run_txn(1'b0, 3, 8'hFF, 0);
    run_txn(1'b1, 5, 0, 8'h01);
    run_txn(1'b1, 5, 0, 8'h80);

    // R10: held request, inputs changed while busy, done and accept coincide
    @(negedge clk);
    req_valid = 1'b1; req_rd = 1'b0; req_addr = 4'h6; req_wdata = 8'hC3;
    @(negedge clk);
    req_addr = 4'h9; req_wdata = 8'h5A;
    wait_done(n);
    check_result(1'b0, 6, 8'hC3, 0, n);
    chk(rsp_done && req_ready, "R10 done with ready", int'({rsp_done, req_ready}), 3);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 accepted in done cycle", int'(req_ready), 0);
    wait_done(n);
    check_result(1'b0, 9, 8'h5A, 0, n);
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule